// File: doc/BRIEF.md
# Edge-Triggered Line Interrupt and Wakeup Controller

The controller watches 30 incoming lines and turns activity on them into interrupt requests, one-cycle event pulses and a single wakeup signal for the power controller. Most lines are configurable. Each of these lines passes through a two-stage synchronizer and an edge detector, and each line can select a rising edge, a falling edge or both. Software can also fire a configurable line through a trigger register. A selected trigger on a line whose interrupt mask is set latches a pending flag. The flag holds the line's interrupt request until software clears it. The same trigger produces a one-clock event pulse when the line's event mask is set.

A smaller group of direct lines has no pending flag and no edge selection. A direct line is gated with the stop-mode input, and only a rising edge of that gated signal counts. So a direct line does nothing while the system runs. In stop mode it gives a one-clock interrupt pulse and/or event pulse, according to its masks, and it always wakes the system.

Software reaches the six registers through a simple word-wide bus. The bus has a write strobe and a word index, and read data comes back combinationally for the index that is presented.

Top module: `line_irq_ctrl`

## Requirements
- R1: After reset, the interrupt mask reads 0x37800000, so only the direct lines are unmasked. The other five registers read 0, and `irq_o`, `evt_o` and `wakeup_o` are low. Word indices are: 0 interrupt mask, 1 event mask, 2 rising select, 3 falling select, 4 software trigger, 5 pending. Bit n of each register belongs to line n.
- R2: Lines 0–17 and 19–22 are configurable, and lines 23–26, 28 and 29 are direct. Bits 18, 27, 30 and 31 read 0 and ignore writes. In the select, software-trigger and pending registers, the bits of direct lines also read 0. Writing all ones gives 0x37FBFFFF in the mask registers and 0x007BFFFF in the select registers.
- R3: A rising edge on a configurable line whose rising select and interrupt mask are 1 sets that line's pending bit and raises `irq_o` for it. Both become visible after the third rising clock edge that follows the input change.
- R4: When both selects of a line are 1, a rising edge and a falling edge each set pending. A line whose selects are both 0 ignores both kinds of edge.
- R5: A trigger on a line whose interrupt mask is 0 leaves its pending bit at 0 and `irq_o` low.
- R6: A trigger on a line whose event mask is 1 raises that line's `evt_o` for exactly one clock, in the same cycle in which pending would appear. An event alone never sets a pending bit.
- R7: Writing 1 to a pending bit clears it and drops the matching `irq_o`. Writing 0 to a pending bit leaves it unchanged.
- R8: A write to the rising or falling select register that changes a line's bit clears that line's pending bit, along with its software-trigger bit. Lines whose bits do not change are unaffected.
- R9: Writing 1 to a software-trigger bit that reads 0 has three effects, all visible one clock after the write. It sets the pending bit if the line's interrupt mask is 1. It gives a one-clock event pulse if the line's event mask is 1. The software-trigger bit then reads 1 until the pending bit is cleared. Writing 1 again while the bit is 1 has no further effect.
- R10: A hardware trigger detected in the same cycle as a write to the rising or falling select register does not set pending.
- R11: A direct line acts on a rising edge of (synchronized line AND `stop_i`). It gives a one-clock `irq_o` pulse if its interrupt mask is 1 and a one-clock `evt_o` pulse if its event mask is 1. It never sets a pending bit. While `stop_i` is low it produces nothing.
- R12: `wakeup_o` is high whenever any `irq_o` or `evt_o` bit is high. It is also high for one clock after a detected direct-line edge, even when both masks of that line are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| line_i | input | 30 | Asynchronous line inputs, bit n is line n |
| stop_i | input | 1 | Stop-mode flag, synchronous to clk_i |
| wr_i | input | 1 | Register write strobe |
| widx_i | input | 3 | Register word index (byte offset / 4) |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for the register selected by widx_i |
| irq_o | output | 30 | Per-line interrupt requests |
| evt_o | output | 30 | Per-line one-clock event pulses |
| wakeup_o | output | 1 | Wakeup request |

## Verification
A pending bit that is wrongly set or lost shows up on the `irq_o` bit of that line in the same cycle. It is also visible at once through a read of the pending word. A stuck software-trigger bit shows as a missing event pulse on the next software write, and as a nonzero read of the trigger word after pending is cleared. An edge detector or synchronizer that is off by one stage moves the event pulse, or widens it beyond one clock, relative to the third clock edge after the input change. The bench samples at exactly that cycle, so such a shift is reported in the cycle where it happens. A direct-line gate that ignores the stop flag shows as a wakeup while the system runs.

// File: rtl/lic_pkg.sv
package lic_pkg;
  localparam int REG_AW = 3;

  typedef enum logic [REG_AW-1:0] {
    RS_IMASK = 3'd0,
    RS_EMASK = 3'd1,
    RS_RISE  = 3'd2,
    RS_FALL  = 3'd3,
    RS_SWTRG = 3'd4,
    RS_PEND  = 3'd5
  } reg_sel_e;
endpackage

// File: rtl/lic_sync.sv
module lic_sync #(
  parameter int W      = 30,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/lic_edge.sv
module lic_edge #(
  parameter int W = 30
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= d_i;
  end

  for (genvar g = 0; g < W; g++) begin : g_bit
    assign rise_o[g] = d_i[g] & ~prev_q[g];
    assign fall_o[g] = ~d_i[g] & prev_q[g];

    // R6: a detected edge lasts a single cycle
    assert_edge_single_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rise_o[g] |=> !rise_o[g]);
  end
endmodule

// File: rtl/lic_regs.sv
module lic_regs
  import lic_pkg::*;
#(
  parameter int             LINES    = 30,
  parameter int             DW       = 32,
  parameter logic [LINES-1:0] CFG_MASK = 30'h007B_FFFF,
  parameter logic [LINES-1:0] DIR_MASK = 30'h3780_0000,
  parameter logic [LINES-1:0] IM_RST   = 30'h3F84_0000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [REG_AW-1:0] widx_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  input  logic [LINES-1:0]  trig_i,
  output logic [LINES-1:0]  imask_o,
  output logic [LINES-1:0]  emask_o,
  output logic [LINES-1:0]  rise_o,
  output logic [LINES-1:0]  fall_o,
  output logic [LINES-1:0]  pend_o,
  output logic [LINES-1:0]  sw_pulse_o
);
  localparam logic [LINES-1:0] MASK_WR = CFG_MASK | DIR_MASK;

  typedef logic [DW-1:0] word_t;

  logic [LINES-1:0] imask_q, emask_q, rise_q, fall_q, sw_q, pend_q;
  logic [LINES-1:0] wd, sens_chg, pend_clr, pend_set;
  logic wr_im, wr_em, wr_ri, wr_fa, wr_sw, wr_pd;
  reg_sel_e sel;

  assign sel   = reg_sel_e'(widx_i);
  assign wd    = wdata_i[LINES-1:0];
  assign wr_im = wr_i && sel == RS_IMASK;
  assign wr_em = wr_i && sel == RS_EMASK;
  assign wr_ri = wr_i && sel == RS_RISE;
  assign wr_fa = wr_i && sel == RS_FALL;
  assign wr_sw = wr_i && sel == RS_SWTRG;
  assign wr_pd = wr_i && sel == RS_PEND;

  if (DW > LINES) begin : g_hi
    logic unused_hi;
    assign unused_hi = ^wdata_i[DW-1:LINES];
  end

  always_comb begin
    sens_chg = '0;
    if (wr_ri) sens_chg = (wd ^ rise_q) & CFG_MASK;
    if (wr_fa) sens_chg = (wd ^ fall_q) & CFG_MASK;
    sw_pulse_o = wr_sw ? (wd & CFG_MASK & ~sw_q) : '0;
    pend_clr   = (wr_pd ? (wd & CFG_MASK) : '0) | sens_chg;
    // R10: hardware triggers are dropped while a select register is written
    pend_set   = (((wr_ri || wr_fa) ? '0 : trig_i) | sw_pulse_o) & imask_q & CFG_MASK;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      imask_q <= IM_RST & MASK_WR;
      emask_q <= '0;
      rise_q  <= '0;
      fall_q  <= '0;
      sw_q    <= '0;
      pend_q  <= '0;
    end else begin
      if (wr_im) imask_q <= wd & MASK_WR;
      if (wr_em) emask_q <= wd & MASK_WR;
      if (wr_ri) rise_q  <= wd & CFG_MASK;
      if (wr_fa) fall_q  <= wd & CFG_MASK;
      sw_q   <= (sw_q | sw_pulse_o) & ~pend_clr;
      pend_q <= (pend_q & ~pend_clr) | pend_set;
    end
  end

  always_comb begin
    unique case (sel)
      RS_IMASK: rdata_o = word_t'(imask_q);
      RS_EMASK: rdata_o = word_t'(emask_q);
      RS_RISE:  rdata_o = word_t'(rise_q);
      RS_FALL:  rdata_o = word_t'(fall_q);
      RS_SWTRG: rdata_o = word_t'(sw_q);
      RS_PEND:  rdata_o = word_t'(pend_q);
      default:  rdata_o = '0;
    endcase
  end

  assign imask_o = imask_q;
  assign emask_o = emask_q;
  assign rise_o  = rise_q;
  assign fall_o  = fall_q;
  assign pend_o  = pend_q;

  assert_pend_masked_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((pend_q & ~$past(pend_q) & ~$past(imask_q)) == '0));

  assert_pend_w1c_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_pd && trig_i == '0) |=> ((pend_q & $past(wd)) == '0));

  assert_sel_write_blocks_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ri || wr_fa) |=> ((pend_q & ~$past(pend_q)) == '0));

  assert_sw_holds_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_pulse_o != '0) |=> ((sw_q & $past(sw_pulse_o)) == $past(sw_pulse_o)));
endmodule

// File: rtl/line_irq_ctrl.sv
module line_irq_ctrl
  import lic_pkg::*;
#(
  parameter int               LINES      = 30,
  parameter int               DW         = 32,
  parameter int               SYNC_STAGES = 2,
  parameter logic [LINES-1:0] CFG_MASK   = 30'h007B_FFFF,
  parameter logic [LINES-1:0] DIR_MASK   = 30'h3780_0000,
  parameter logic [LINES-1:0] IM_RST     = 30'h3F84_0000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [LINES-1:0]  line_i,
  input  logic              stop_i,
  input  logic              wr_i,
  input  logic [REG_AW-1:0] widx_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  output logic [LINES-1:0]  irq_o,
  output logic [LINES-1:0]  evt_o,
  output logic              wakeup_o
);
  logic [LINES-1:0] sync_w, cfg_rise, cfg_fall, dir_in, dir_rise, unused_dir_fall;
  logic [LINES-1:0] imask, emask, rise_sel, fall_sel, pend, sw_pulse, hw_trig, dir_hit;
  logic [LINES-1:0] evt_q, dir_q;

  lic_sync #(.W(LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(line_i), .q_o(sync_w)
  );

  lic_edge #(.W(LINES)) u_cfg_edge (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(sync_w), .rise_o(cfg_rise), .fall_o(cfg_fall)
  );

  assign dir_in = sync_w & {LINES{stop_i}} & DIR_MASK;

  lic_edge #(.W(LINES)) u_dir_edge (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(dir_in), .rise_o(dir_rise), .fall_o(unused_dir_fall)
  );

  assign hw_trig = ((cfg_rise & rise_sel) | (cfg_fall & fall_sel)) & CFG_MASK;
  assign dir_hit = dir_rise & DIR_MASK;

  lic_regs #(
    .LINES(LINES), .DW(DW), .CFG_MASK(CFG_MASK), .DIR_MASK(DIR_MASK), .IM_RST(IM_RST)
  ) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr_i), .widx_i(widx_i), .wdata_i(wdata_i),
    .rdata_o(rdata_o), .trig_i(hw_trig), .imask_o(imask), .emask_o(emask),
    .rise_o(rise_sel), .fall_o(fall_sel), .pend_o(pend), .sw_pulse_o(sw_pulse)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      evt_q <= '0;
      dir_q <= '0;
    end else begin
      evt_q <= (hw_trig | sw_pulse | dir_hit) & emask;
      dir_q <= dir_hit;
    end
  end

  assign irq_o    = (pend | dir_q) & imask;
  assign evt_o    = evt_q;
  assign wakeup_o = (|irq_o) | (|evt_q) | (|dir_q);

  assert_dir_idle_run_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stop_i |=> (dir_q == '0));

  assert_no_dir_pend_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend & DIR_MASK) == '0);

  assert_evt_needs_mask_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((evt_q & ~$past(emask)) == '0));
endmodule

// File: tb/sim_line_irq_ctrl.sv
module sim_line_irq_ctrl;
  localparam int LINES = 30;

  typedef struct {
    int          kind;   // 0 read word, 1 irq, 2 evt, 3 wakeup
    logic [31:0] exp;
    string       req;
  } item_t;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [LINES-1:0]  line = '0;
  logic              stop = 1'b0;
  logic              wr = 1'b0;
  logic [2:0]        widx = '0;
  logic [31:0]       wdata = '0;
  logic [31:0]       rdata;
  logic [LINES-1:0]  irq, evt;
  logic              wake;

  item_t sb_q[$];
  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  line_irq_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .line_i(line), .stop_i(stop), .wr_i(wr),
    .widx_i(widx), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq), .evt_o(evt),
    .wakeup_o(wake)
  );

  // monitor: compares queued expectations shortly after each falling edge
  always begin
    @(negedge clk);
    #2;
    while (sb_q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = sb_q.pop_front();
      case (it.kind)
        0:       act = rdata;
        1:       act = 32'(irq);
        2:       act = 32'(evt);
        default: act = {31'd0, wake};
      endcase
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s kind=%0d actual=%h expected=%h", it.req, it.kind, act, it.exp);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected<100000 cycles", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic push(int kind, logic [31:0] exp, string req);
    item_t it;
    it.kind = kind; it.exp = exp; it.req = req;
    sb_q.push_back(it);
  endtask

  task automatic wr_reg(logic [2:0] idx, logic [31:0] d);
    wr = 1'b1; widx = idx; wdata = d;
    tick();
    wr = 1'b0;
  endtask

  task automatic rd_chk(logic [2:0] idx, logic [31:0] exp, string req);
    widx = idx;
    push(0, exp, req);
    tick();
  endtask

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick();
    // R1 reset state
    push(1, 0, "R1"); push(2, 0, "R1"); push(3, 0, "R1");
    rd_chk(0, 32'h3780_0000, "R1");
    for (int i = 1; i < 6; i++) rd_chk(3'(i), 32'h0, "R1");

    // R2 reserved and direct bits
    wr_reg(0, 32'hFFFF_FFFF); rd_chk(0, 32'h37FB_FFFF, "R2");
    wr_reg(2, 32'hFFFF_FFFF); rd_chk(2, 32'h007B_FFFF, "R2");
    wr_reg(0, 32'h3780_0003); wr_reg(2, 32'h0);

    // R3 rising edge on line 0
    wr_reg(2, 32'h1);
    line = 30'h1; tick(3);
    push(1, 32'h1, "R3"); rd_chk(5, 32'h1, "R3");
    // R7 write-0 keeps, write-1 clears
    wr_reg(5, 32'h0); rd_chk(5, 32'h1, "R7");
    wr_reg(5, 32'h1); push(1, 32'h0, "R7"); rd_chk(5, 32'h0, "R7");

    // R4 both edges on line 1, falling ignored on line 0
    wr_reg(2, 32'h3); wr_reg(3, 32'h2);
    line = 30'h3; tick(3);
    push(1, 32'h2, "R4"); rd_chk(5, 32'h2, "R4");
    wr_reg(5, 32'h2);
    line = 30'h0; tick(3);
    push(1, 32'h2, "R4"); rd_chk(5, 32'h2, "R4");
    wr_reg(5, 32'h2);

    // R5/R6 masked interrupt, single event pulse on line 2
    wr_reg(1, 32'hC); wr_reg(2, 32'h7);
    line = 30'h4; tick(3);
    push(2, 32'h4, "R6"); push(1, 32'h0, "R5"); push(3, 32'h1, "R12");
    rd_chk(5, 32'h0, "R5");
    push(2, 32'h0, "R6"); push(3, 32'h0, "R12");
    tick();

    // R9 software trigger on line 3
    wr_reg(0, 32'h3780_000B);
    wr_reg(4, 32'h8);
    push(2, 32'h8, "R9"); push(1, 32'h8, "R9");
    rd_chk(4, 32'h8, "R9");
    push(2, 32'h0, "R9"); rd_chk(5, 32'h8, "R9");
    wr_reg(4, 32'h8);
    push(2, 32'h0, "R9"); rd_chk(5, 32'h8, "R9");
    wr_reg(5, 32'h8);
    rd_chk(4, 32'h0, "R9"); push(1, 32'h0, "R9"); rd_chk(5, 32'h0, "R9");

    // R8 select change clears only the changed line
    line = 30'h7; tick(3);
    rd_chk(5, 32'h3, "R8");
    wr_reg(2, 32'h6);
    push(1, 32'h2, "R8"); rd_chk(5, 32'h2, "R8");
    wr_reg(5, 32'h2); rd_chk(5, 32'h0, "R8");

    // R10 edge coincident with select write is dropped
    wr_reg(3, 32'h0);
    line = 30'h5; tick(3);
    rd_chk(5, 32'h0, "R10");
    line = 30'h7; tick(2);
    wr_reg(2, 32'h6);
    push(1, 32'h0, "R10"); rd_chk(5, 32'h0, "R10");
    rd_chk(5, 32'h0, "R10");

    // R11 direct lines
    wr_reg(1, 32'h0100_000C);
    line = 30'h7 | (30'h1 << 23); tick(3);
    push(1, 32'h0, "R11"); push(2, 32'h0, "R11"); push(3, 32'h0, "R11");
    tick();
    push(3, 32'h0, "R11");
    line = 30'h7; tick(3);
    stop = 1'b1; tick(2);
    line = 30'h7 | (30'h1 << 23); tick(3);
    push(1, 32'h0080_0000, "R11"); push(2, 32'h0, "R11"); push(3, 32'h1, "R12");
    rd_chk(5, 32'h0, "R11");
    push(1, 32'h0, "R11"); push(3, 32'h0, "R11");
    line = 30'h7 | (30'h3 << 23); tick(3);
    push(1, 32'h0100_0000, "R11"); push(2, 32'h0100_0000, "R11"); push(3, 32'h1, "R12");
    tick();
    push(1, 32'h0, "R11"); push(2, 32'h0, "R11");

    // R12 masked direct edge still wakes
    wr_reg(0, 32'h3580_000B);
    line = 30'h7 | (30'h7 << 23); tick(3);
    push(1, 32'h0, "R12"); push(2, 32'h0, "R12"); push(3, 32'h1, "R12");
    tick();
    push(3, 32'h0, "R12");
    tick(2);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule